// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block produces the timing for one direction of a serial audio port. It runs only on a fast network clock and uses a cascade of dividers to make a serial bit clock. The cascade has an optional halving stage, a selectable divide-by-one-or-eight prescaler and an 8-bit programmable ratio. A final toggle stage gives the bit clock an even duty cycle. Bit-clock rising edges are counted into words and words into frames. A frame-sync pulse marks the last bit period of every frame, so the sync pulse leads the first bit of word zero by one bit period. All divided clocks are clock-enable pulses inside the network-clock domain, and the pin-level clocks come from registers.

A direction control selects the source of the pins. When it is high, the generated bit clock and frame sync drive the pins and the output enables are high. When it is low, the pins copy the external clock and sync inputs, and the output enables are low. A gated mode keeps the bit clock parked low unless the transmit-active flag is high.

The bit clock comes from a three-state machine. PARK holds the clock low while it is idle. HIGH is the high phase. LOW is the running low phase. Every transition happens on a divider tick:
- PARK to HIGH when running is allowed.
- HIGH to LOW always.
- LOW to HIGH when running is allowed.
- LOW to PARK when it is not.

Running is allowed when gating is off or transmit-active is high.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is high and for the cycles after it until the first divider tick, `bclk_out` and `fsync_out` are 0. With `drive_int` = 1, both output enables are 1.
- R2: Each bit-clock phase lasts T network-clock cycles. T = H × P × (N+1), where H = 2 if `half_en` = 1 (else 1), P = 8 if `pre8_en` = 1 (else 1), and N is `div_n`.
- R3: A `div_n` value of N divides by N+1 for every N from 0 to 255.
- R4: While running, the high and low phases of the bit clock are equally long, which gives a 50% duty cycle.
- R5: A new divider setting takes effect only at the next terminal count. The phase in progress finishes with the old ratio.
- R6: With `drive_int` = 0, `bclk_out` equals `ext_bclk_in` and `fsync_out` equals `ext_fsync_in` combinationally, and both output enables are 0.
- R7: With `gate_en` = 1 and `tx_active` = 0, a parked or low bit clock stays low. With `gate_en` = 0, the bit clock runs whatever the value of `tx_active`.
- R8: In gated mode, the bit clock starts toggling once `tx_active` rises. Within two phases after `tx_active` falls, it returns low and then stays low.
- R9: `wl_code` selects the bits per word: 0→8, 1→10, 2→12, 3→16, 4→18, 5→20, 6→22, 7→24, and 8 to 15→16.
- R10: A `frame_len` of D gives D+1 words per frame. `fsync_out` is 1 for exactly one bit period, during the last bit of each frame. That is every W×(D+1) rising edges, counted from reset.
- R11: The internal frame sync changes only together with a rising edge of the internal bit clock, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock, the only clock |
| rst | input | 1 | Synchronous reset, active high |
| half_en | input | 1 | Enable the halving stage |
| pre8_en | input | 1 | Prescaler divides by 8 when 1 |
| div_n | input | DIV_W | Programmable ratio minus one |
| wl_code | input | 4 | Word-length code |
| frame_len | input | FR_W | Words per frame minus one |
| drive_int | input | 1 | 1: drive generated clocks; 0: follow external pins |
| gate_en | input | 1 | Gated clock mode |
| tx_active | input | 1 | Data is being shifted |
| ext_bclk_in | input | 1 | External bit clock |
| ext_fsync_in | input | 1 | External frame sync |
| bclk_out | output | 1 | Bit clock at the pin |
| fsync_out | output | 1 | Frame sync at the pin |
| bclk_oe | output | 1 | Bit-clock pin output enable |
| fsync_oe | output | 1 | Frame-sync pin output enable |

## Verification
A stage counter holding the wrong value or a stale ratio lengthens or shortens the next bit-clock phase. That error shows at the pin within one phase of T cycles. A word or bit counter that drifts shifts the frame-sync pulse away from its multiple of W×(D+1) rising edges, and this shows in the first frame after the fault. A state machine that takes the wrong path while gated either shows a clock edge while transmit is idle, or shows no restart after transmit-active rises. Either is visible within two phases.

// File: rtl/audio_clkgen_pkg.sv
`timescale 1ns/1ps
package audio_clkgen_pkg;
    localparam int WLC_W  = 4;
    localparam int BITS_W = 5;

    typedef enum logic [1:0] {
        BCK_PARK = 2'd0,
        BCK_HIGH = 2'd1,
        BCK_LOW  = 2'd2
    } bck_state_t;

    // bits per word for a word-length code; unused codes give 16
    function automatic logic [BITS_W-1:0] word_bits(input logic [WLC_W-1:0] code);
        logic [BITS_W-1:0] b;
        case (code)
            4'd0:    b = 5'd8;
            4'd1:    b = 5'd10;
            4'd2:    b = 5'd12;
            4'd3:    b = 5'd16;
            4'd4:    b = 5'd18;
            4'd5:    b = 5'd20;
            4'd6:    b = 5'd22;
            4'd7:    b = 5'd24;
            default: b = 5'd16;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/acg_divstage.sv
`timescale 1ns/1ps
module acg_divstage #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_in,
    input  logic [W-1:0] lim,
    output logic         en_out
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim_q;

    assign en_out = en_in && (cnt == lim_q);

    // ratio is sampled only at terminal count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            lim_q <= lim;
        end else if (en_in) begin
            if (cnt == lim_q) begin
                cnt   <= '0;
                lim_q <= lim;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acg_prescale.sv
`timescale 1ns/1ps
module acg_prescale #(
    parameter int DIV_W     = 8,
    parameter int PRE_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_en,
    input  logic             pre8_en,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

    logic en_half;
    logic en_pre;

    acg_divstage #(.W(1)) u_half (
        .clk(clk), .rst(rst), .en_in(1'b1), .lim(half_en), .en_out(en_half)
    );

    generate
        if (PRE_RATIO > 1) begin : g_pre
            logic [PRE_W-1:0] lim_pre;
            assign lim_pre = pre8_en ? PRE_W'(PRE_RATIO - 1) : '0;
            acg_divstage #(.W(PRE_W)) u_pre (
                .clk(clk), .rst(rst), .en_in(en_half), .lim(lim_pre), .en_out(en_pre)
            );
        end else begin : g_nopre
            assign en_pre = en_half;
        end
    endgenerate

    acg_divstage #(.W(DIV_W)) u_prog (
        .clk(clk), .rst(rst), .en_in(en_pre), .lim(div_n), .en_out(tick)
    );
endmodule

// File: rtl/acg_bitgate.sv
`timescale 1ns/1ps
module acg_bitgate
    import audio_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gate_en,
    input  logic tx_active,
    output logic bclk,
    output logic rise
);
    bck_state_t st;
    bck_state_t st_nx;
    logic       run_ok;

    assign run_ok = !gate_en || tx_active;

    always_comb begin
        st_nx = st;
        if (tick) begin
            unique case (st)
                BCK_PARK: if (run_ok) st_nx = BCK_HIGH;
                BCK_HIGH: st_nx = BCK_LOW;
                BCK_LOW:  st_nx = run_ok ? BCK_HIGH : BCK_PARK;
                default:  st_nx = BCK_PARK;
            endcase
        end
    end

    assign rise = (st_nx == BCK_HIGH) && (st != BCK_HIGH);

    always_ff @(posedge clk) begin
        if (rst) st <= BCK_PARK;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) bclk <= 1'b0;
        else     bclk <= (st_nx == BCK_HIGH);
    end
endmodule

// File: rtl/acg_framer.sv
`timescale 1ns/1ps
module acg_framer
    import audio_clkgen_pkg::*;
#(
    parameter int FR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic [WLC_W-1:0]  wl_code,
    input  logic [FR_W-1:0]   frame_len,
    output logic              fsync,
    output logic [BITS_W-1:0] bit_cnt,
    output logic [FR_W-1:0]   word_cnt,
    output logic [BITS_W-1:0] wl_q,
    output logic [FR_W-1:0]   fw_q
);
    logic last_bit;
    logic last_word;

    assign last_bit  = (bit_cnt == wl_q - 1'b1);
    assign last_word = (word_cnt == fw_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            word_cnt <= '0;
            wl_q     <= word_bits(wl_code);
            fw_q     <= frame_len;
            fsync    <= 1'b0;
        end else if (rise) begin
            fsync <= last_bit && last_word;
            if (last_bit) begin
                bit_cnt <= '0;
                if (last_word) begin
                    word_cnt <= '0;
                    wl_q     <= word_bits(wl_code);
                    fw_q     <= frame_len;
                end else begin
                    word_cnt <= word_cnt + 1'b1;
                end
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int FR_W      = 5,
    parameter int PRE_RATIO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_en,
    input  logic             pre8_en,
    input  logic [DIV_W-1:0] div_n,
    input  logic [WLC_W-1:0] wl_code,
    input  logic [FR_W-1:0]  frame_len,
    input  logic             drive_int,
    input  logic             gate_en,
    input  logic             tx_active,
    input  logic             ext_bclk_in,
    input  logic             ext_fsync_in,
    output logic             bclk_out,
    output logic             fsync_out,
    output logic             bclk_oe,
    output logic             fsync_oe
);
    logic              tick;
    logic              bclk_int;
    logic              rise;
    logic              fsync_int;
    logic [BITS_W-1:0] bit_cnt;
    logic [BITS_W-1:0] wl_q;
    logic [FR_W-1:0]   word_cnt;
    logic [FR_W-1:0]   fw_q;

    acg_prescale #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_pre (
        .clk(clk), .rst(rst), .half_en(half_en), .pre8_en(pre8_en),
        .div_n(div_n), .tick(tick)
    );

    acg_bitgate u_bck (
        .clk(clk), .rst(rst), .tick(tick), .gate_en(gate_en),
        .tx_active(tx_active), .bclk(bclk_int), .rise(rise)
    );

    acg_framer #(.FR_W(FR_W)) u_frm (
        .clk(clk), .rst(rst), .rise(rise), .wl_code(wl_code),
        .frame_len(frame_len), .fsync(fsync_int), .bit_cnt(bit_cnt),
        .word_cnt(word_cnt), .wl_q(wl_q), .fw_q(fw_q)
    );

    assign bclk_out  = drive_int ? bclk_int  : ext_bclk_in;
    assign fsync_out = drive_int ? fsync_int : ext_fsync_in;
    assign bclk_oe   = drive_int;
    assign fsync_oe  = drive_int;
endmodule

// File: rtl/audio_clkgen_chk.sv
`timescale 1ns/1ps
module audio_clkgen_chk
    import audio_clkgen_pkg::*;
#(
    parameter int FR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bclk_int,
    input logic              fsync_int,
    input logic              gate_en,
    input logic              tx_active,
    input logic [BITS_W-1:0] bit_cnt,
    input logic [BITS_W-1:0] wl_q,
    input logic [FR_W-1:0]   word_cnt,
    input logic [FR_W-1:0]   fw_q
);
    assert_park_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !tx_active && !bclk_int) |=> !bclk_int);

    assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(bclk_int) && !$past(rst)) |-> $past(tick));

    assert_fsync_on_rise_R11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(fsync_int) && !$past(rst)) |-> $rose(bclk_int));

    assert_bit_range_R9: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < wl_q);

    assert_word_range_R10: assert property (@(posedge clk) disable iff (rst)
        word_cnt <= fw_q);
endmodule

bind audio_clkgen audio_clkgen_chk #(.FR_W(FR_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .bclk_int(bclk_int),
    .fsync_int(fsync_int), .gate_en(gate_en), .tx_active(tx_active),
    .bit_cnt(bit_cnt), .wl_q(wl_q), .word_cnt(word_cnt), .fw_q(fw_q)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_en = 1'b0;
    logic       pre8_en = 1'b0;
    logic [7:0] div_n = 8'd0;
    logic [3:0] wl_code = 4'd0;
    logic [4:0] frame_len = 5'd0;
    logic       drive_int = 1'b1;
    logic       gate_en = 1'b0;
    logic       tx_active = 1'b0;
    logic       ext_bclk_in = 1'b0;
    logic       ext_fsync_in = 1'b0;
    logic       bclk_out, fsync_out, bclk_oe, fsync_oe;

    always #4 clk = ~clk;

    audio_clkgen uut (
        .clk(clk), .rst(rst), .half_en(half_en), .pre8_en(pre8_en),
        .div_n(div_n), .wl_code(wl_code), .frame_len(frame_len),
        .drive_int(drive_int), .gate_en(gate_en), .tx_active(tx_active),
        .ext_bclk_in(ext_bclk_in), .ext_fsync_in(ext_fsync_in),
        .bclk_out(bclk_out), .fsync_out(fsync_out),
        .bclk_oe(bclk_oe), .fsync_oe(fsync_oe)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    per_q[$];
    int    fs_q[$];
    string cur_tag = "R1";
    int    cyc = 0;
    int    last_cyc = 0;
    int    tog_cnt = 0;
    logic  prev_b = 1'b0;
    event  tog_ev;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: measures phase lengths and frame-sync per rising edge
    always @(negedge clk) begin
        int iv;
        cyc++;
        if (bclk_out !== prev_b) begin
            iv = cyc - last_cyc;
            last_cyc = cyc;
            tog_cnt++;
            if (per_q.size() > 0) check(cur_tag, iv, per_q.pop_front());
            if (bclk_out === 1'b1 && fs_q.size() > 0)
                check(cur_tag, int'(fsync_out), fs_q.pop_front());
            prev_b = bclk_out;
            -> tog_ev;
        end
    end

    function automatic int bench_bits(input int code);
        case (code)
            0: return 8;   1: return 10;  2: return 12;  3: return 16;
            4: return 18;  5: return 20;  6: return 22;  7: return 24;
            default: return 16;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_period(input bit h, input bit p, input int n, input string tag);
        int t;
        half_en = h; pre8_en = p; div_n = 8'(n);
        gate_en = 1'b0; drive_int = 1'b1;
        do_reset();
        repeat (3) @(tog_ev);
        cur_tag = tag;
        t = (h ? 2 : 1) * (p ? 8 : 1) * (n + 1);
        repeat (6) per_q.push_back(t);
        wait (per_q.size() == 0);
    endtask

    task automatic run_frame(input int code, input int fl, input int nfr, input string tag);
        int len;
        half_en = 1'b0; pre8_en = 1'b0; div_n = 8'd0; gate_en = 1'b0;
        wl_code = 4'(code); frame_len = 5'(fl);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        cur_tag = tag;
        len = bench_bits(code) * (fl + 1);
        for (int k = 0; k < len * nfr; k++)
            fs_q.push_back(((k % len) == len - 1) ? 1 : 0);
        @(negedge clk);
        rst = 1'b0;
        wait (fs_q.size() == 0);
    endtask

    task automatic run_all();
        int n0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 bclk", int'(bclk_out), 0);
        check("R1 fsync", int'(fsync_out), 0);
        check("R1 oe", int'(bclk_oe & fsync_oe), 1);

        run_period(0, 0, 0,   "R2 R4");
        run_period(1, 0, 2,   "R2 R4");
        run_period(0, 1, 1,   "R2 R4");
        run_period(1, 1, 3,   "R2 R3");
        run_period(0, 0, 255, "R3 R4");

        // R5: change ratio right after a terminal count
        half_en = 0; pre8_en = 0; div_n = 8'd3; gate_en = 0;
        do_reset();
        repeat (3) @(tog_ev);
        @(tog_ev);
        div_n = 8'd1;
        cur_tag = "R5";
        per_q.push_back(4); per_q.push_back(2); per_q.push_back(2);
        wait (per_q.size() == 0);

        run_frame(0, 2, 3,  "R9 R10");
        run_frame(7, 0, 3,  "R9 R10");
        run_frame(15, 1, 2, "R9 R10");
        run_frame(2, 0, 3,  "R9 R10");
        run_frame(0, 31, 2, "R10");

        // R7 / R8: gated mode
        div_n = 8'd0; gate_en = 1'b1; tx_active = 1'b0;
        do_reset();
        n0 = tog_cnt;
        repeat (40) @(negedge clk);
        check("R7 gated idle toggles", tog_cnt - n0, 0);
        check("R7 gated idle level", int'(bclk_out), 0);
        tx_active = 1'b1;
        n0 = tog_cnt;
        repeat (20) @(negedge clk);
        check("R8 restart", int'(tog_cnt - n0 > 4), 1);
        tx_active = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 parked level", int'(bclk_out), 0);
        n0 = tog_cnt;
        repeat (30) @(negedge clk);
        check("R8 stays parked", tog_cnt - n0, 0);
        gate_en = 1'b0;
        n0 = tog_cnt;
        repeat (20) @(negedge clk);
        check("R7 ungated runs", int'(tog_cnt - n0 > 4), 1);

        // R6: external source
        drive_int = 1'b0;
        ext_bclk_in = 1'b1; ext_fsync_in = 1'b0;
        #1;
        check("R6 bclk follows", int'(bclk_out), 1);
        check("R6 fsync follows", int'(fsync_out), 0);
        check("R6 oe low", int'(bclk_oe | fsync_oe), 0);
        @(negedge clk);
        ext_bclk_in = 1'b0; ext_fsync_in = 1'b1;
        #1;
        check("R6 bclk follows", int'(bclk_out), 0);
        check("R6 fsync follows", int'(fsync_out), 1);
        drive_int = 1'b1;
        #1;
        check("R6 oe high", int'(bclk_oe & fsync_oe), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule